// File: doc/BRIEF.md
# Key-Guarded Watchdog Timer

This block is a watchdog timer driven from a simple register write and read port. Software must feed it before the count reaches a programmed limit. If it does not, the block raises a timeout flag and sends a one-cycle reset request to the system. The port exposes four 32-bit words, addressed by word index: control/status, counter, limit and window.

Both feeding and reconfiguration are guarded by two-word key sequences, which are written to the counter word. A refresh key pair restarts the count. An unlock key pair opens a short configuration window. While that window is open, software may change the limit, the window word and the control fields. The control fields are the run enable, the update permission and the tick source. A write to control/status applies the new setting, closes the window and raises a "configuration applied" status bit.

The count advances on one of four tick sources: every bus cycle, or the rising edges of one of three slower clock inputs. Those inputs are brought into the bus domain through edge-detect synchronizers. If update permission is cleared, the block refuses every later unlock until a system reset.

Top module: `keyed_wdt`

## Requirements
- R1: After reset: control/status reads 0x0000_0020 (update permission bit 5 set, all else 0), count 0, limit 0xFFFF, window 0, reset_req low.
- R2: Word index 0 is control/status, 1 is the counter, 2 is the limit (16 bits), 3 is the window (16 bits); reads are combinational and zero-extended.
- R3: Writing 0x0000A602 and then 0x0000B480 to word 1 clears the count to 0 at that second write.
- R4: A key pair whose second word is wrong, or whose words come in reverse order, is discarded with no action.
- R5: Writing 0x0000C520 and then 0x0000D928 to word 1 sets bit 11 (unlocked); writes to the limit, window or control fields while bit 11 is 0 are ignored.
- R6: A write to word 0 while unlocked applies bit 7 (run), bit 5 (update permission) and bits 9:8 (source), clears bit 11 and sets bit 10 (applied); the next unlock clears bit 10.
- R7: The unlocked window closes by itself after ULK_CYC bus cycles.
- R8: Once bit 5 has been written as 0, unlock sequences have no effect until reset.
- R9: With run set, the count steps by one on each tick of the selected source: source 0 ticks every bus cycle, sources 1 to 3 on rising edges of aux_clk[0..2]. Unselected inputs have no effect, and with run clear the count holds.
- R10: A tick that finds the count equal to the limit sets the count to 0, sets bit 14 (flag) and drives reset_req high for exactly one cycle.
- R11: Writing word 0 with bit 14 set clears the flag whether locked or not. Writing it with bit 14 clear leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one cycle |
| waddr | input | 2 | Word index of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for waddr |
| aux_clk | input | 3 | Slow tick sources 1 to 3, asynchronous |
| reset_req | output | 1 | One-cycle system reset request on timeout |

## Verification
The bench interrupts key pairs with a stray word and sends them in reverse order. A sequencer that kept stale state, or that acted on either word alone, would clear the count when it should not. The bench measures the exact cycle and the width of the timeout pulse. A limit compare that is off by one moves that pulse a cycle, and a level output would stay high. It toggles the unselected slow inputs while one source is selected, which exposes a wrong source mux. It also checks that the unlock window expires, that a locked write leaves the limit and the run bit unchanged, and that clearing update permission blocks every later unlock until reset.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam logic [1:0] A_CTL = 2'd0;
    localparam logic [1:0] A_CNT = 2'd1;
    localparam logic [1:0] A_TOV = 2'd2;
    localparam logic [1:0] A_WIN = 2'd3;

    localparam logic [31:0] KEY_REF_A = 32'h0000_A602;
    localparam logic [31:0] KEY_REF_B = 32'h0000_B480;
    localparam logic [31:0] KEY_ULK_A = 32'h0000_C520;
    localparam logic [31:0] KEY_ULK_B = 32'h0000_D928;

    localparam int B_FLAG = 14;
    localparam int B_OPEN = 11;
    localparam int B_DONE = 10;
    localparam int B_SRC  = 8;
    localparam int B_RUN  = 7;
    localparam int B_UPD  = 5;

    typedef enum logic [1:0] {KS_IDLE, KS_REF, KS_ULK} key_st_e;

    typedef struct packed {
        logic       run;
        logic       upd_ok;
        logic [1:0] src;
    } ctl_t;

    function automatic ctl_t ctl_from_word(logic [31:0] w);
        ctl_t c;
        c.run    = w[B_RUN];
        c.upd_ok = w[B_UPD];
        c.src    = w[B_SRC+1:B_SRC];
        return c;
    endfunction

    function automatic logic [31:0] status_word(ctl_t c, logic flag, logic open, logic done);
        logic [31:0] w;
        w                 = '0;
        w[B_FLAG]         = flag;
        w[B_OPEN]         = open;
        w[B_DONE]         = done;
        w[B_SRC+1:B_SRC]  = c.src;
        w[B_RUN]          = c.run;
        w[B_UPD]          = c.upd_ok;
        return w;
    endfunction

endpackage

// File: rtl/wdt_edge_sync.sv
module wdt_edge_sync #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] rise
);
    for (genvar i = 0; i < N; i++) begin : g_sync
        logic [2:0] sh;
        always_ff @(posedge clk) begin
            if (rst) sh <= '0;
            else     sh <= {sh[1:0], async_in[i]};
        end
        assign rise[i] = sh[1] & ~sh[2];
    end
endmodule

// File: rtl/wdt_keyseq.sv
module wdt_keyseq
    import wdt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_key,
    input  logic [31:0] key,
    output logic        refresh_hit,
    output logic        unlock_hit
);
    key_st_e st_q;

    always_comb begin
        refresh_hit = wr_key && (st_q == KS_REF) && (key == KEY_REF_B);
        unlock_hit  = wr_key && (st_q == KS_ULK) && (key == KEY_ULK_B);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= KS_IDLE;
        end else if (wr_key) begin
            if (st_q == KS_IDLE) begin
                if (key == KEY_REF_A)      st_q <= KS_REF;
                else if (key == KEY_ULK_A) st_q <= KS_ULK;
            end else begin
                st_q <= KS_IDLE;
            end
        end
    end
endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         tick,
    input  logic         clr,
    input  logic [W-1:0] limit,
    output logic [W-1:0] count,
    output logic         fire,
    output logic         hit
);
    always_comb fire = !clr && run && tick && (count == limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            hit   <= 1'b0;
        end else begin
            hit <= fire;
            if (clr)            count <= '0;
            else if (fire)      count <= '0;
            else if (run && tick) count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
    import wdt_pkg::*;
#(
    parameter int TOV_W   = 16,
    parameter int ULK_CYC = 128,
    parameter int SRC_W   = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [1:0]               waddr,
    input  logic [31:0]              wdata,
    output logic [31:0]              rdata,
    input  logic [(1<<SRC_W)-2:0]    aux_clk,
    output logic                     reset_req
);
    localparam int N_AUX = (1 << SRC_W) - 1;
    localparam int TMR_W = $clog2(ULK_CYC + 1);

    ctl_t             ctl_q;
    logic             flag_q, open_q, ready_q;
    logic [TOV_W-1:0] tov_q, win_q, cnt_q;
    logic [TMR_W-1:0] tmr_q;
    logic [N_AUX-1:0] aux_rise;
    logic [N_AUX:0]   tick_vec;
    logic             tick, refresh_hit, unlock_hit, fire, hit;
    logic             wr_ctl, wr_cfg_ok;

    wdt_edge_sync #(.N(N_AUX)) u_sync (
        .clk(clk), .rst(rst), .async_in(aux_clk), .rise(aux_rise)
    );

    wdt_keyseq u_keys (
        .clk(clk), .rst(rst), .wr_key(wr_en && waddr == A_CNT), .key(wdata),
        .refresh_hit(refresh_hit), .unlock_hit(unlock_hit)
    );

    assign tick_vec = {aux_rise, 1'b1};
    assign tick     = tick_vec[ctl_q.src];

    wdt_count #(.W(TOV_W)) u_cnt (
        .clk(clk), .rst(rst), .run(ctl_q.run), .tick(tick), .clr(refresh_hit),
        .limit(tov_q), .count(cnt_q), .fire(fire), .hit(hit)
    );

    assign reset_req = hit;
    assign wr_ctl    = wr_en && waddr == A_CTL;
    assign wr_cfg_ok = wr_en && open_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q   <= '{run: 1'b0, upd_ok: 1'b1, src: '0};
            flag_q  <= 1'b0;
            open_q  <= 1'b0;
            ready_q <= 1'b0;
            tov_q   <= '1;
            win_q   <= '0;
            tmr_q   <= '0;
        end else begin
            if (fire)                     flag_q <= 1'b1;
            else if (wr_ctl && wdata[B_FLAG]) flag_q <= 1'b0;

            if (open_q) begin
                if (tmr_q <= TMR_W'(1)) open_q <= 1'b0;
                else                    tmr_q  <= tmr_q - 1'b1;
            end

            if (wr_cfg_ok && waddr == A_TOV) tov_q <= wdata[TOV_W-1:0];
            if (wr_cfg_ok && waddr == A_WIN) win_q <= wdata[TOV_W-1:0];
            if (wr_cfg_ok && waddr == A_CTL) begin
                ctl_q   <= ctl_from_word(wdata);
                open_q  <= 1'b0;
                ready_q <= 1'b1;
            end

            if (unlock_hit && ctl_q.upd_ok) begin
                open_q  <= 1'b1;
                ready_q <= 1'b0;
                tmr_q   <= TMR_W'(ULK_CYC);
            end
        end
    end

    always_comb begin
        unique case (waddr)
            A_CTL:   rdata = status_word(ctl_q, flag_q, open_q, ready_q);
            A_CNT:   rdata = 32'(cnt_q);
            A_TOV:   rdata = 32'(tov_q);
            default: rdata = 32'(win_q);
        endcase
    end
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk
    import wdt_pkg::*;
#(
    parameter int TOV_W   = 16,
    parameter int ULK_CYC = 128
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [1:0]       waddr,
    input logic             reset_req,
    input logic             flag_q,
    input logic             open_q,
    input logic             ready_q,
    input logic             run,
    input logic             upd_ok,
    input logic [TOV_W-1:0] cnt_q,
    input logic [TOV_W-1:0] tov_q,
    input logic             refresh_hit,
    input logic             unlock_hit
);
    int open_len;
    always_ff @(posedge clk) begin
        if (rst || !open_q) open_len <= 0;
        else                open_len <= open_len + 1;
    end

    // R10
    pulse_flag_chk: assert property (@(posedge clk) disable iff (rst) reset_req |-> flag_q);
    // R3
    refresh_clr_chk: assert property (@(posedge clk) disable iff (rst) refresh_hit |=> cnt_q == '0);
    // R5
    locked_tov_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && waddr == A_TOV && !open_q) |=> $stable(tov_q));
    // R6
    close_apply_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && waddr == A_CTL && open_q) |=> (!open_q && ready_q));
    // R8
    lockout_chk: assert property (@(posedge clk) disable iff (rst)
        (unlock_hit && !upd_ok && !open_q) |=> !open_q);
    // R9
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !refresh_hit) |=> $stable(cnt_q));
    // R7
    open_len_chk: assert property (@(posedge clk) disable iff (rst) open_len <= ULK_CYC);
endmodule

bind keyed_wdt wdt_chk #(.TOV_W(TOV_W), .ULK_CYC(ULK_CYC)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .waddr(waddr), .reset_req(reset_req),
    .flag_q(flag_q), .open_q(open_q), .ready_q(ready_q), .run(ctl_q.run),
    .upd_ok(ctl_q.upd_ok), .cnt_q(cnt_q), .tov_q(tov_q),
    .refresh_hit(refresh_hit), .unlock_hit(unlock_hit)
);

// File: tb/tb_keyed_wdt.sv
module tb_keyed_wdt;
    localparam int CLK_PERIOD = 10;
    localparam int ULK = 16;

    logic        clk = 0, rst = 1, wr_en = 0, reset_req;
    logic [1:0]  waddr = 0;
    logic [31:0] wdata = 0, rdata;
    logic [2:0]  aux_clk = 0;
    int checks = 0, errors = 0;
    logic done = 0;

    keyed_wdt #(.TOV_W(16), .ULK_CYC(ULK), .SRC_W(2)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .waddr(waddr), .wdata(wdata),
        .rdata(rdata), .aux_clk(aux_clk), .reset_req(reset_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        wr_en = 1; waddr = a; wdata = d;
        @(negedge clk);
        wr_en = 0; wdata = 0;
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] v);
        waddr = a; #1; v = rdata;
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic unlock();
        wr(2'd1, 32'h0000_C520); wr(2'd1, 32'h0000_D928);
    endtask

    task automatic refresh();
        wr(2'd1, 32'h0000_A602); wr(2'd1, 32'h0000_B480);
    endtask

    task automatic do_reset();
        rst = 1; cyc(3); rst = 0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(2'd0, v); chk("R1 ctl", v, 32'h20);
        rd(2'd1, v); chk("R1 cnt", v, 0);
        rd(2'd2, v); chk("R1/R2 tov", v, 32'hFFFF);
        rd(2'd3, v); chk("R1/R2 win", v, 0);
        chk("R1 reset_req", {31'd0, reset_req}, 0);
    endtask

    task automatic t_cfg();
        logic [31:0] v;
        wr(2'd2, 32'h1234);
        rd(2'd2, v); chk("R5 locked tov write ignored", v, 32'hFFFF);
        unlock();
        rd(2'd0, v); chk("R5 unlocked bit11", v, 32'h0820);
        wr(2'd2, 32'h0040); wr(2'd3, 32'h0033);
        wr(2'd0, 32'h0220);
        rd(2'd0, v); chk("R6 applied, closed", v, 32'h0620);
        rd(2'd2, v); chk("R2 tov word", v, 32'h40);
        rd(2'd3, v); chk("R2 win word", v, 32'h33);
        wr(2'd3, 32'h0077);
        rd(2'd3, v); chk("R5 locked win write ignored", v, 32'h33);
        unlock();
        rd(2'd0, v); chk("R6 unlock clears bit10", v, 32'h0A20);
        wr(2'd0, 32'h0020);
    endtask

    task automatic t_expiry();
        logic [31:0] v;
        unlock(); cyc(ULK/2);
        rd(2'd0, v); chk("R7 still open mid window", v[11], 1);
        cyc(ULK);
        rd(2'd0, v); chk("R7 window expired", v[11], 0);
        wr(2'd2, 32'h0099);
        rd(2'd2, v); chk("R7/R5 write after expiry ignored", v, 32'h40);
    endtask

    task automatic t_timeout();
        logic [31:0] v;
        int first = -1, n = 0, flag_at = 0;
        unlock(); wr(2'd2, 32'd5); wr(2'd0, 32'h00A0);
        for (int k = 0; k < 10; k++) begin
            if (reset_req) begin n++; if (first < 0) first = k; end
            if (k == 6) begin rd(2'd0, v); flag_at = v[14]; end
            @(negedge clk);
        end
        chk("R10 pulse cycle", first, 6);
        chk("R10 pulse width", n, 1);
        chk("R10 flag set", flag_at, 1);
        unlock(); wr(2'd0, 32'h0020);
        rd(2'd0, v); chk("R11 write 0 keeps flag", v[14], 1);
        wr(2'd0, 32'h4080);
        rd(2'd0, v); chk("R11/R5 locked clear, run unchanged", v, 32'h0420);
        rd(2'd1, v); cyc(5);
        begin
            logic [31:0] w;
            rd(2'd1, w); chk("R9 count holds when stopped", w, v);
        end
    endtask

    task automatic t_refresh();
        logic [31:0] v;
        unlock(); wr(2'd2, 32'hFFFF); wr(2'd0, 32'h00A0);
        cyc(30);
        refresh();
        rd(2'd1, v); chk("R3 refresh clears count", v, 0);
        cyc(10);
        wr(2'd1, 32'h0000_A602); wr(2'd1, 32'h0000_1234); wr(2'd1, 32'h0000_B480);
        rd(2'd1, v); chk("R4 broken pair no clear", v > 12, 1);
        wr(2'd1, 32'h0000_B480); wr(2'd1, 32'h0000_A602);
        rd(2'd1, v); chk("R4 reversed pair no clear", v > 14, 1);
        wr(2'd1, 32'h0);
        unlock(); wr(2'd0, 32'h0020);
    endtask

    task automatic pulses(int idx, int n);
        for (int i = 0; i < n; i++) begin
            aux_clk[idx] = 1; cyc(3); aux_clk[idx] = 0; cyc(3);
        end
    endtask

    task automatic t_source();
        logic [31:0] v;
        unlock(); wr(2'd2, 32'd1000); wr(2'd0, 32'h01A0);
        refresh();
        pulses(1, 5); pulses(2, 3); cyc(5);
        rd(2'd1, v); chk("R9 unselected sources ignored", v, 0);
        pulses(0, 4); cyc(5);
        rd(2'd1, v); chk("R9 selected source counts edges", v, 4);
        unlock(); wr(2'd0, 32'h0020);
    endtask

    task automatic t_lockout();
        logic [31:0] v;
        unlock(); wr(2'd0, 32'h0000);
        unlock();
        rd(2'd0, v); chk("R8 unlock refused", v[11], 0);
        wr(2'd2, 32'h22);
        rd(2'd2, v); chk("R8 config stays locked", v, 32'd1000);
        do_reset();
        unlock();
        rd(2'd0, v); chk("R8 reset restores unlock", v[11], 1);
    endtask

    initial begin
        @(negedge clk); do_reset();
        t_reset();
        t_cfg();
        t_expiry();
        t_timeout();
        t_refresh();
        t_source();
        t_lockout();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule